// File: doc/BRIEF.md
# Atomic Message Receive Port

This block is the receive half of a network interface that software reaches through registers. Flits come in from the network on a valid/ready handshake and are written into a single message buffer in arrival order. Once the final flit of a message has landed, the message is reported to software in one of two ways. A polled status flag is always raised. An interrupt request is raised as well unless software has chosen polling mode or is inside an atomic section.

Software reads any stored word by putting its index on an index port, and it reads the word count from a length port. When it has finished with the message it pulses a dispose command, and the buffer is free again on the next cycle. While a message waits for dispose, the network sees backpressure, so later arrivals wait in the network and are never lost. Messages marked as system traffic always raise the interrupt, whatever the mode or atomic state. A dispose issued when no message is held has no effect on the buffer, but it sets a sticky error flag.

Top module: `msg_rx_port`

## Requirements
- R1: After reset, flit_ready is 1 and msg_avail, irq, disp_err and msg_len are all 0.
- R2: A flit is accepted on a rising edge where flit_valid and flit_ready are both 1, and it is stored at the index equal to its position in the message (first flit at index 0). While a complete message is held, flit_ready is 0, so no flit is accepted or lost.
- R3: A message completes on the edge that accepts a flit with flit_last=1, or on the edge that accepts the DEPTH-th flit, whichever comes first. msg_avail is 0 before that edge and 1 right after it.
- R4: While msg_avail is 1, rd_data combinationally shows the stored word at rd_idx, and msg_len gives the number of words in the message. Both hold steady until dispose.
- R5: With poll_mode=0 and atomic_hold=0, irq is 1 exactly while a complete message is held.
- R6: While atomic_hold is 1, irq stays 0 for a non-system message. Dropping atomic_hold while that message is still held raises irq in the same cycle.
- R7: With poll_mode=1, irq stays 0 for a non-system message, and msg_avail stays 1 until a dispose.
- R8: If any flit of a message has flit_sys=1, irq is 1 while that message is held, regardless of poll_mode and atomic_hold.
- R9: A dispose pulse while msg_avail is 1 makes msg_avail and irq 0, msg_len 0 and flit_ready 1 on the next cycle.
- R10: A dispose pulse while msg_avail is 0 leaves msg_avail, flit_ready and msg_len unchanged and sets disp_err. disp_err stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flit_valid | input | 1 | Network offers a flit |
| flit_data | input | W | Flit payload word |
| flit_last | input | 1 | Flit is the tail of its message |
| flit_sys | input | 1 | Flit belongs to a system message |
| flit_ready | output | 1 | Port can take a flit this cycle |
| poll_mode | input | 1 | 1 selects polling; user messages never interrupt |
| atomic_hold | input | 1 | 1 while software is inside an atomic section |
| rd_idx | input | $clog2(DEPTH) | Index of the word to read |
| rd_data | output | W | Stored word at rd_idx |
| msg_len | output | $clog2(DEPTH)+1 | Word count of the held message |
| dispose | input | 1 | One-cycle command to free the held message |
| msg_avail | output | 1 | A complete message is held |
| irq | output | 1 | Interrupt request |
| disp_err | output | 1 | Sticky: dispose was issued with nothing held |

## Verification
The bench targets the edge where the tail flit is accepted. A design that reports the message early would show msg_avail while the message is still partial, and one that reports it late would leave software polling a cycle behind. It sends a DEPTH-word message with no tail marker. Without the implicit close, the port would hang waiting for a tail, or it would overwrite index 0. It also drives flits at the port while a message is held: a design without backpressure would overwrite stored words or change msg_len. Random runs mix polling, atomic sections and system messages. A design with the gating wrong would either interrupt inside an atomic section or miss the system-message override. Disposing with nothing held must only set the sticky flag and must leave the next message untouched.

// File: rtl/msg_rx_port.sv
module msg_rx_port #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int LW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flit_valid,
  input  logic [W-1:0]  flit_data,
  input  logic          flit_last,
  input  logic          flit_sys,
  output logic          flit_ready,
  input  logic          poll_mode,
  input  logic          atomic_hold,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic [LW-1:0] msg_len,
  input  logic          dispose,
  output logic          msg_avail,
  output logic          irq,
  output logic          disp_err
);

  logic [W-1:0]  mem [DEPTH];
  logic [LW-1:0] cnt;
  logic          done, msg_sys, err;

  wire take   = flit_valid && flit_ready;
  wire closes = flit_last || (cnt == LW'(DEPTH - 1));

  assign flit_ready = !done;
  assign msg_avail  = done;
  assign msg_len    = cnt;
  assign disp_err   = err;
  assign rd_data    = mem[rd_idx];
  assign irq        = done && (msg_sys || (!poll_mode && !atomic_hold));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      done    <= 1'b0;
      msg_sys <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (dispose) begin
        if (done) begin
          done    <= 1'b0;
          cnt     <= '0;
          msg_sys <= 1'b0;
        end else begin
          err <= 1'b1;
        end
      end
      if (take) begin
        cnt     <= cnt + 1'b1;
        msg_sys <= msg_sys | flit_sys;
        if (closes) done <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) mem[cnt[IW-1:0]] <= flit_data;
  end

endmodule

// File: rtl/msg_rx_port_chk.sv
module msg_rx_port_chk #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flit_ready,
  input logic          poll_mode,
  input logic          atomic_hold,
  input logic [LW-1:0] msg_len,
  input logic          dispose,
  input logic          msg_avail,
  input logic          irq,
  input logic          disp_err,
  input logic          msg_sys
);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    msg_avail |-> !flit_ready);

  p_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_avail && !dispose) |=> (msg_avail && $stable(msg_len)));

  p_irq_needs_msg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> msg_avail);

  p_gate_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_avail && !msg_sys && (poll_mode || atomic_hold)) |-> !irq);

  p_sys_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_avail && msg_sys) |-> irq);

  p_dispose_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dispose && msg_avail) |=> (!msg_avail && msg_len == '0 && flit_ready));

  p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dispose && !msg_avail) |=> disp_err);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    disp_err |=> disp_err);

endmodule

bind msg_rx_port msg_rx_port_chk #(.W(W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .flit_ready(flit_ready), .poll_mode(poll_mode),
  .atomic_hold(atomic_hold), .msg_len(msg_len), .dispose(dispose),
  .msg_avail(msg_avail), .irq(irq), .disp_err(disp_err), .msg_sys(msg_sys)
);

// File: tb/msg_rx_port_tb_top.sv
module msg_rx_port_tb_top;
  localparam int W = 32, DEPTH = 8, IW = $clog2(DEPTH), LW = IW + 1;

  logic clk = 0, rst_n = 0;
  logic flit_valid = 0, flit_last = 0, flit_sys = 0, poll_mode = 0, atomic_hold = 0, dispose = 0;
  logic [W-1:0] flit_data = '0;
  logic [IW-1:0] rd_idx = '0;
  logic flit_ready, msg_avail, irq, disp_err;
  logic [W-1:0] rd_data;
  logic [LW-1:0] msg_len;

  int tests = 0, fails = 0, cyc = 0;
  logic [W-1:0] exp_w [DEPTH];
  logic exp_err = 0;

  always #5 clk = ~clk;

  msg_rx_port #(.W(W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid), .flit_data(flit_data),
    .flit_last(flit_last), .flit_sys(flit_sys), .flit_ready(flit_ready),
    .poll_mode(poll_mode), .atomic_hold(atomic_hold), .rd_idx(rd_idx),
    .rd_data(rd_data), .msg_len(msg_len), .dispose(dispose),
    .msg_avail(msg_avail), .irq(irq), .disp_err(disp_err));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic exp_irq(logic avail, logic sys, logic poll, logic atom);
    return avail && (sys || (!poll && !atom));
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_msg(int len, logic sys, logic tail);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      while ($urandom % 4 == 0) begin flit_valid = 0; @(negedge clk); end
      flit_valid = 1;
      flit_data  = $urandom;
      flit_last  = tail && (i == len - 1);
      flit_sys   = sys && (i == len / 2);
      exp_w[i]   = flit_data;
      #1;
      check("R3 not complete before tail", {31'd0, msg_avail}, 0);
      check("R2 ready while filling", {31'd0, flit_ready}, 1);
    end
    @(negedge clk);
    flit_valid = 0; flit_last = 0; flit_sys = 0;
  endtask

  task automatic verify_msg(int len, logic sys);
    #1;
    check("R3 complete after tail", {31'd0, msg_avail}, 1);
    check("R4 length", {{(W-LW){1'b0}}, msg_len}, len);
    check("R5/R6/R7/R8 irq", {31'd0, irq}, {31'd0, exp_irq(1, sys, poll_mode, atomic_hold)});
    for (int i = 0; i < len; i++) begin
      rd_idx = IW'(i); #1;
      check("R4 read word", rd_data, exp_w[i]);
    end
  endtask

  task automatic push_blocked;
    @(negedge clk);
    flit_valid = 1; flit_data = 32'hdead_beef; flit_last = 1; #1;
    check("R2 backpressure", {31'd0, flit_ready}, 0);
    @(negedge clk);
    flit_valid = 0; flit_last = 0; #1;
  endtask

  task automatic do_dispose;
    logic had = msg_avail;
    @(negedge clk); dispose = 1;
    @(negedge clk); dispose = 0; #1;
    if (!had) exp_err = 1;
    check(had ? "R9 avail cleared" : "R10 avail unchanged", {31'd0, msg_avail}, 0);
    check(had ? "R9 ready" : "R10 ready unchanged", {31'd0, flit_ready}, 1);
    check(had ? "R9 len zero" : "R10 len unchanged", {{(W-LW){1'b0}}, msg_len}, 0);
    check("R9 irq cleared", {31'd0, irq}, 0);
    check("R10 disp_err", {31'd0, disp_err}, {31'd0, exp_err});
  endtask

  initial begin
    void'($urandom(32'd20240511));
    repeat (3) @(negedge clk);
    #1;
    check("R1 ready", {31'd0, flit_ready}, 1);
    check("R1 avail", {31'd0, msg_avail}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 err", {31'd0, disp_err}, 0);
    check("R1 len", {{(W-LW){1'b0}}, msg_len}, 0);
    rst_n = 1;

    // Interrupt mode, short message
    send_msg(3, 0, 1);
    verify_msg(3, 0);
    push_blocked();
    verify_msg(3, 0);
    do_dispose();

    // Full-depth message with no tail closes itself (R3)
    send_msg(DEPTH, 0, 0);
    verify_msg(DEPTH, 0);
    push_blocked();
    do_dispose();

    // Atomic section, then leave it (R6)
    atomic_hold = 1;
    send_msg(2, 0, 1);
    verify_msg(2, 0);
    @(negedge clk); atomic_hold = 0; #1;
    check("R6 irq after leaving atomic", {31'd0, irq}, 1);
    do_dispose();

    // Polling mode holds message with no irq (R7)
    poll_mode = 1;
    send_msg(4, 0, 1);
    repeat (5) @(negedge clk);
    verify_msg(4, 0);
    check("R7 no irq in poll", {31'd0, irq}, 0);
    do_dispose();

    // System message overrides poll and atomic (R8)
    atomic_hold = 1;
    send_msg(5, 1, 1);
    verify_msg(5, 1);
    check("R8 sys irq", {31'd0, irq}, 1);
    do_dispose();
    poll_mode = 0; atomic_hold = 0;

    // Dispose with nothing held (R10)
    do_dispose();
    do_dispose();
    send_msg(1, 0, 1);
    verify_msg(1, 0);
    do_dispose();

    // Random mix
    for (int k = 0; k < 40; k++) begin
      int len = 1 + ($urandom % DEPTH);
      logic sys = ($urandom % 4 == 0);
      poll_mode   = $urandom % 2;
      atomic_hold = $urandom % 2;
      send_msg(len, sys, 1);
      verify_msg(len, sys);
      if ($urandom % 3 == 0) push_blocked();
      if (atomic_hold && !sys) begin
        @(negedge clk); atomic_hold = 0; #1;
        check("R6 release", {31'd0, irq}, {31'd0, !poll_mode});
      end
      do_dispose();
      if ($urandom % 8 == 0) do_dispose();
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule